// File: doc/BRIEF.md
# DSP Address Pointer Unit

This unit generates data-memory addresses for a signal-processing datapath. It holds a small bank of pointer registers. Each pointer has its own buffer base and buffer length. On each command cycle the pointer named by the command is put on the address output unchanged, and it is then rewritten at the clock edge according to the chosen stepping mode.

Five stepping modes are available:
- **Linear:** plain increment or decrement, wrapping at the word width.
- **Circular increment and decrement:** the pointer is kept inside the window that starts at the base and spans the buffer length. A delay line can therefore write each new sample over the oldest one and advance, with no shifting of stored samples.
- **Bit-reversed:** the step is added with the carry running from the most significant bit toward the least significant bit. This produces the scrambled index order used by FFT data passes.

Load strobes write a pointer, a base or a length. Writing a base or a length puts the pointer back at the base.

Top module: `agu_top`

## Requirements
- R1: After reset every pointer, base and length is zero, so `addr_out` reads 0 for every value of `cmd_sel`.
- R2: `addr_out` always shows the current value of the pointer chosen by `cmd_sel`. During a command cycle this is the value before the update. The updated value appears from the next cycle.
- R3: Mode code 0 adds `cmd_step` to the pointer and mode code 1 subtracts it. Both wrap modulo 2^AW.
- R4: Mode code 2 (circular increment) sets the pointer to base + ((ptr − base + step) mod len), for step < len. If the sum reaches or passes base + len, len is subtracted.
- R5: Mode code 3 (circular decrement) subtracts the step. If the result would fall below base, len is added, so the pointer stays in [base, base + len).
- R6: Mode code 4 (bit-reversed) adds `cmd_step` with the carry propagating from bit AW−1 toward bit 0. The carry out of bit 0 is dropped. With step 4 the pointer runs 0, 4, 2, 6, 1, 5, 3, 7, 0.
- R7: Writing the base (`ld_base_en`) or the length (`ld_len_en`) sets that pointer to its base, using the new base if one is written in the same cycle. This overrides a pointer load and a command in the same cycle.
- R8: `ld_ptr_en` writes `ld_data` into the pointer chosen by `ld_sel`.
- R9: A load to the same pointer as a command in the same cycle takes priority over the command. A load and a command aimed at different pointers both take effect.
- R10: Mode codes 5 to 7, and any cycle with `cmd_valid` low, leave every pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_sel | input | SELW | Pointer chosen for the command and for `addr_out` |
| cmd_mode | input | 3 | Stepping mode code |
| cmd_step | input | AW | Step amount (half the transform size in bit-reversed mode) |
| ld_sel | input | SELW | Pointer targeted by the load strobes |
| ld_ptr_en | input | 1 | Write `ld_data` into the pointer |
| ld_base_en | input | 1 | Write `ld_data` into the base; pointer goes to base |
| ld_len_en | input | 1 | Write `ld_data` into the length; pointer goes to base |
| ld_data | input | AW | Load value |
| addr_out | output | AW | Current value of the selected pointer |

## Verification
A load and a stepping command can arrive in the same cycle. The bench provokes this twice with both aimed at one pointer, and once with them aimed at two different pointers. It then reads back every affected pointer through `cmd_sel` on the following cycle. The result is judged correct only if the load value alone survives on a shared target, and if both the load and the step land when the targets differ. A base write paired with a pointer write also checks that the base reset wins.

// File: rtl/agu_pkg.sv
// Package: stepping mode codes shared by the address pointer unit.
// Assumes a 3-bit mode field; codes above 4 mean "no update".
package agu_pkg;
    typedef enum logic [2:0] {
        AM_LIN_INC = 3'd0,
        AM_LIN_DEC = 3'd1,
        AM_MOD_INC = 3'd2,
        AM_MOD_DEC = 3'd3,
        AM_BREV    = 3'd4
    } am_mode_t;

    // True when a mode code rewrites the pointer.
    function automatic logic mode_moves(input logic [2:0] m);
        return (m <= 3'd4);
    endfunction
endpackage

// File: rtl/agu_step_calc.sv
// agu_step_calc: combinational next-pointer arithmetic for one command.
// Assumes step < len in the circular modes and ptr within [base, base+len).
module agu_step_calc #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] nxt
);
    import agu_pkg::*;

    // Reverse the bit order of a word.
    function automatic logic [AW-1:0] flip(input logic [AW-1:0] x);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = x[AW-1-i];
        return r;
    endfunction

    logic [AW-1:0] off;
    logic [AW:0]   up_sum;
    logic [AW:0]   dn_res;

    // Circular offset arithmetic, one extra bit to hold the carry.
    always_comb begin
        off    = ptr - base;
        up_sum = {1'b0, off} + {1'b0, step};
        if (up_sum >= {1'b0, len}) up_sum = up_sum - {1'b0, len};
        if (off < step) dn_res = {1'b0, off} + {1'b0, len} - {1'b0, step};
        else            dn_res = {1'b0, off} - {1'b0, step};
    end

    // Mode selection of the next pointer value.
    always_comb begin
        case (mode)
            AM_LIN_INC: nxt = ptr + step;
            AM_LIN_DEC: nxt = ptr - step;
            AM_MOD_INC: nxt = base + up_sum[AW-1:0];
            AM_MOD_DEC: nxt = base + dn_res[AW-1:0];
            AM_BREV:    nxt = flip(flip(ptr) + flip(step));
            default:    nxt = ptr;
        endcase
    end
endmodule

// File: rtl/agu_ptr_reg.sv
// agu_ptr_reg: one pointer with its base and length registers.
// Load priority: base/length write (pointer to base) > pointer write > update.
module agu_ptr_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_ptr,
    input  logic          ld_base,
    input  logic          ld_len,
    input  logic [AW-1:0] ld_data,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_next,
    output logic [AW-1:0] ptr_q,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] len_q
);
    // Register writes with the load priority above.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            base_q <= '0;
            len_q  <= '0;
        end else begin
            if (ld_base) base_q <= ld_data;
            if (ld_len)  len_q  <= ld_data;
            if (ld_base)     ptr_q <= ld_data;
            else if (ld_len) ptr_q <= base_q;
            else if (ld_ptr) ptr_q <= ld_data;
            else if (upd_en) ptr_q <= upd_next;
        end
    end

    // R7: base or length write returns the pointer to the base.
    p_base_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_base || ld_len) |=> (ptr_q == base_q));

    // R8: plain pointer write lands.
    p_ptr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ptr && !ld_base && !ld_len) |=> (ptr_q == $past(ld_data)));

    // R9: pointer write beats a same-cycle update.
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && ld_ptr && !ld_base && !ld_len) |=> (ptr_q == $past(ld_data)));

    // R10: no load and no update leaves the pointer alone.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !ld_ptr && !ld_base && !ld_len) |=> $stable(ptr_q));
endmodule

// File: rtl/agu_top.sv
// agu_top: bank of NPTR address pointers with a shared step calculator.
// One command per cycle; addr_out shows the selected pointer before update.
module agu_top #(
    parameter  int AW   = 32,
    parameter  int NPTR = 4,
    localparam int SELW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [SELW-1:0] cmd_sel,
    input  logic [2:0]      cmd_mode,
    input  logic [AW-1:0]   cmd_step,
    input  logic [SELW-1:0] ld_sel,
    input  logic            ld_ptr_en,
    input  logic            ld_base_en,
    input  logic            ld_len_en,
    input  logic [AW-1:0]   ld_data,
    output logic [AW-1:0]   addr_out
);
    import agu_pkg::*;

    logic [AW-1:0] ptr_arr  [NPTR];
    logic [AW-1:0] base_arr [NPTR];
    logic [AW-1:0] len_arr  [NPTR];
    logic [AW-1:0] sel_base;
    logic [AW-1:0] sel_len;
    logic [AW-1:0] step_next;
    logic          cmd_moves;
    logic          ld_hit;

    // Selected pointer context for the shared calculator.
    always_comb begin
        addr_out  = ptr_arr[cmd_sel];
        sel_base  = base_arr[cmd_sel];
        sel_len   = len_arr[cmd_sel];
        cmd_moves = cmd_valid && mode_moves(cmd_mode);
        ld_hit    = (ld_ptr_en || ld_base_en || ld_len_en) && (ld_sel == cmd_sel);
    end

    agu_step_calc #(.AW(AW)) calc_i (
        .ptr  (addr_out),
        .base (sel_base),
        .len  (sel_len),
        .mode (cmd_mode),
        .step (cmd_step),
        .nxt  (step_next)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        agu_ptr_reg #(.AW(AW)) reg_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_ptr   (ld_ptr_en  && (ld_sel == SELW'(g))),
            .ld_base  (ld_base_en && (ld_sel == SELW'(g))),
            .ld_len   (ld_len_en  && (ld_sel == SELW'(g))),
            .ld_data  (ld_data),
            .upd_en   (cmd_moves  && (cmd_sel == SELW'(g))),
            .upd_next (step_next),
            .ptr_q    (ptr_arr[g]),
            .base_q   (base_arr[g]),
            .len_q    (len_arr[g])
        );
    end

    // R3: linear increment lands one cycle later.
    p_lin_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_mode == AM_LIN_INC && !ld_hit)
        |=> (ptr_arr[$past(cmd_sel)] == $past(addr_out + cmd_step)));

    // R4/R5: circular step keeps an in-window pointer in its window.
    p_mod_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_mode == AM_MOD_INC || cmd_mode == AM_MOD_DEC) && !ld_hit
         && cmd_step < sel_len && (addr_out - sel_base) < sel_len)
        |=> ((ptr_arr[$past(cmd_sel)] - base_arr[$past(cmd_sel)]) < len_arr[$past(cmd_sel)]));
endmodule

// File: tb/agu_top_tb.sv
// Bench for agu_top: vector table walk, then directed reset and priority tests.
module agu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_sel = '0;
    logic [2:0]  cmd_mode = '0;
    logic [31:0] cmd_step = '0;
    logic [1:0]  ld_sel = '0;
    logic        ld_ptr_en = 1'b0;
    logic        ld_base_en = 1'b0;
    logic        ld_len_en = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] addr_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] cur [4];

    always #4 clk = ~clk;

    agu_top #(.AW(32), .NPTR(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_mode(cmd_mode), .cmd_step(cmd_step), .ld_sel(ld_sel),
        .ld_ptr_en(ld_ptr_en), .ld_base_en(ld_base_en), .ld_len_en(ld_len_en),
        .ld_data(ld_data), .addr_out(addr_out)
    );

    // op: 0 command, 1 pointer load, 2 base load, 3 length load
    // fields: [70:69] op, [68:67] sel, [66:64] mode, [63:32] value, [31:0] expected
    localparam int NV = 25;
    localparam logic [70:0] VEC [NV] = '{
        {2'd2, 2'd0, 3'd0, 32'd100, 32'd100},
        {2'd3, 2'd0, 3'd0, 32'd8,   32'd100},
        {2'd0, 2'd0, 3'd2, 32'd3,   32'd103},
        {2'd0, 2'd0, 3'd2, 32'd3,   32'd106},
        {2'd0, 2'd0, 3'd2, 32'd3,   32'd101},
        {2'd0, 2'd0, 3'd2, 32'd7,   32'd100},
        {2'd0, 2'd0, 3'd3, 32'd1,   32'd107},
        {2'd0, 2'd0, 3'd3, 32'd7,   32'd100},
        {2'd0, 2'd0, 3'd0, 32'd5,   32'd105},
        {2'd0, 2'd0, 3'd1, 32'd2,   32'd103},
        {2'd1, 2'd1, 3'd0, 32'd0,   32'd0},
        {2'd0, 2'd1, 3'd4, 32'd4,   32'd4},
        {2'd0, 2'd1, 3'd4, 32'd4,   32'd2},
        {2'd0, 2'd1, 3'd4, 32'd4,   32'd6},
        {2'd0, 2'd1, 3'd4, 32'd4,   32'd1},
        {2'd0, 2'd1, 3'd4, 32'd4,   32'd5},
        {2'd0, 2'd1, 3'd4, 32'd4,   32'd3},
        {2'd0, 2'd1, 3'd4, 32'd4,   32'd7},
        {2'd0, 2'd1, 3'd4, 32'd4,   32'd0},
        {2'd2, 2'd2, 3'd0, 32'h1000, 32'h1000},
        {2'd3, 2'd2, 3'd0, 32'd5,   32'h1000},
        {2'd0, 2'd2, 3'd3, 32'd2,   32'h1003},
        {2'd0, 2'd2, 3'd2, 32'd4,   32'h1002},
        {2'd1, 2'd0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {2'd0, 2'd0, 3'd0, 32'd1,   32'd0}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic [2:0] m);
        if (op == 2'd1) return "R8 pointer load";
        if (op != 2'd0) return "R7 base/length load";
        case (m)
            3'd0, 3'd1: return "R3 linear step";
            3'd2:       return "R4 circular increment";
            3'd3:       return "R5 circular decrement";
            default:    return "R6 bit-reversed step";
        endcase
    endfunction

    // Read pointer s through addr_out with no command pending.
    task automatic read_ptr(input logic [1:0] s, input logic [31:0] exp, input string tag);
        cmd_valid = 1'b0; ld_ptr_en = 1'b0; ld_base_en = 1'b0; ld_len_en = 1'b0;
        cmd_sel = s;
        #1;
        check(addr_out, exp, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 4; i++) cur[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every pointer
        for (int i = 0; i < 4; i++) read_ptr(2'(i), 32'd0, "R1 reset value");

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [1:0]  s;
            logic [2:0]  m;
            logic [31:0] val;
            logic [31:0] exp;
            {op, s, m, val, exp} = VEC[v];
            @(negedge clk);
            cmd_sel = s;
            if (op == 2'd0) begin
                cmd_valid = 1'b1; cmd_mode = m; cmd_step = val;
                #1;
                check(addr_out, cur[s], "R2 pre-update address");
            end else begin
                ld_sel = s; ld_data = val;
                ld_ptr_en = (op == 2'd1); ld_base_en = (op == 2'd2); ld_len_en = (op == 2'd3);
            end
            @(negedge clk);
            read_ptr(s, exp, tag_of(op, m));
            cur[s] = exp;
        end

        // R10: reserved mode code and idle strobe leave P0 at 0
        @(negedge clk);
        cmd_sel = 2'd0; cmd_valid = 1'b1; cmd_mode = 3'd5; cmd_step = 32'd3;
        @(negedge clk);
        read_ptr(2'd0, 32'd0, "R10 reserved mode");
        cmd_mode = 3'd0; cmd_step = 32'd9;
        @(negedge clk);
        read_ptr(2'd0, 32'd0, "R10 command strobe low");

        // R9: load and command on the same pointer, load wins
        cmd_valid = 1'b1; cmd_sel = 2'd0; cmd_mode = 3'd0; cmd_step = 32'd1;
        ld_sel = 2'd0; ld_ptr_en = 1'b1; ld_data = 32'd50;
        @(negedge clk);
        read_ptr(2'd0, 32'd50, "R9 same-pointer load wins");

        // R9: load and command on different pointers, both land
        cmd_valid = 1'b1; cmd_sel = 2'd0; cmd_mode = 3'd0; cmd_step = 32'd2;
        ld_sel = 2'd3; ld_ptr_en = 1'b1; ld_data = 32'd7;
        @(negedge clk);
        read_ptr(2'd0, 32'd52, "R9 command on other pointer");
        read_ptr(2'd3, 32'd7,  "R9 load on other pointer");

        // R7: base write beats a same-cycle pointer write and command
        @(negedge clk);
        cmd_valid = 1'b1; cmd_sel = 2'd2; cmd_mode = 3'd0; cmd_step = 32'd1;
        ld_sel = 2'd2; ld_ptr_en = 1'b1; ld_base_en = 1'b1; ld_data = 32'h2000;
        @(negedge clk);
        read_ptr(2'd2, 32'h2000, "R7 base write wins");

        // R7: length write returns pointer to the current base
        cmd_valid = 1'b1; cmd_sel = 2'd2; cmd_mode = 3'd0; cmd_step = 32'd6;
        @(negedge clk);
        read_ptr(2'd2, 32'h2006, "R3 linear step");
        ld_sel = 2'd2; ld_len_en = 1'b1; ld_data = 32'd16;
        @(negedge clk);
        read_ptr(2'd2, 32'h2000, "R7 length write resets");

        @(negedge clk);
        summary();
    end
endmodule